// File: doc/BRIEF.md
# Keyed Non-Volatile Write Guard

This block sits between a CPU's byte-wide register bus and the programming engine of an on-chip non-volatile memory. Software sets up a write through an eight-bit control register. The start bit only takes hold after a two-byte key has been written to a separate unlock location, and the start-bit write has to come straight after the key. The unlock location stores nothing.

Once a write is accepted, the block runs a busy timer of configurable length that stands in for the array's programming time. It holds the start bit high while the timer runs, stalls the CPU while program memory is being written, and raises a one-cycle completion pulse at the end. A warm reset from the reset pin or the watchdog that arrives while a write is running cancels the write and leaves a sticky error flag behind. A cold reset from power-on or brown-out clears everything.

Top module: `nvm_write_guard`

## Requirements
- R1: The control register reads back on `ctl_rdata` in the cycle after a write with this bit layout, from bit 7 down to bit 0: memory select (1 = program memory), configuration select, a reserved bit that always reads 0, erase enable, error flag, write enable, write start, read start.
- R2: The unlock location has no storage, and `key_rdata` reads 0x00 at all times, including just after a key byte is written to it.
- R3: The write-start bit (bit 1) is set only when the unlock location has received 0x55 and then 0xAA, and the very next bus write goes to the control register. Any other bus write in between returns the key tracker to its start: a wrong byte, a repeated 0x55, or a control write.
- R4: A start request is accepted only when the write-enable bit (bit 2) already held 1 before the request was written. A refused request leaves bit 1 at 0, and the other writable bits still take the written value.
- R5: An accepted write keeps bit 1 at 1 for exactly BUSY_CYCLES cycles. On the edge where bit 1 clears, `wr_done` goes high for exactly one cycle.
- R6: `cpu_stall` is high while a write is running with memory select at 1, and low when the running write targets data memory (memory select 0).
- R7: While a write is running, control-register writes have no effect on the register.
- R8: Software cannot set the error flag (bit 3). Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R9: A warm reset (`rst_warm`) clears write enable, write start and read start. It keeps memory select, configuration select, erase enable and the error flag. If a write is running, it cancels the write with no `wr_done` and sets the error flag.
- R10: A cold reset (`rst_cold`) clears the whole register to 0x00 and drops `cpu_stall` and `wr_done`. It takes precedence over `rst_warm`.
- R11: Writing 1 to read start (bit 0) while no write is running sets that bit, and raises `rd_strobe`, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous power-on / brown-out reset, active high |
| rst_warm | input | 1 | Synchronous pin or watchdog reset, active high |
| bus_wdata | input | 8 | Bus write data |
| ctl_we | input | 1 | Write strobe for the control register |
| key_we | input | 1 | Write strobe for the unlock location |
| ctl_rdata | output | 8 | Control register read value |
| key_rdata | output | 8 | Unlock location read value (always zero) |
| cpu_stall | output | 1 | CPU stall during a program-memory write |
| wr_done | output | 1 | One-cycle write completion pulse |
| rd_strobe | output | 1 | One-cycle read request |

## Verification
Every register result, and the `cpu_stall` level that follows from it, is due one clock edge after the bus strobe or reset that causes it. The bench drives inputs on the falling edge and samples on the next falling edge, so it reads each result half a period after the edge that produced it. The completion pulse is due BUSY_CYCLES edges after the accepting edge. The bench therefore counts single cycles after the accept and checks that the start bit is still high, and `wr_done` still low, at every sample before that edge, and that `wr_done` is low again one sample after it. Cancelled writes get a full BUSY_CYCLES window of samples to confirm that no pulse appears.

// File: rtl/nvmg_pkg.sv
package nvmg_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef struct packed {
        logic msel;
        logic csel;
        logic pad;
        logic erase;
        logic err;
        logic wen;
        logic wstart;
        logic rstart;
    } ctl_t;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_HALF  = 2'd1,
        UNL_ARMED = 2'd2
    } unl_e;

    function automatic logic [7:0] ctl_view(ctl_t r);
        return {r.msel, r.csel, 1'b0, r.erase, r.err, r.wen, r.wstart, r.rstart};
    endfunction

    function automatic ctl_t ctl_from_byte(logic [7:0] b);
        ctl_t r;
        r = ctl_t'(b);
        r.pad = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/nvmg_unlock.sv
module nvmg_unlock
    import nvmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_we,
    input  logic       ctl_we,
    input  logic [7:0] wdata,
    output logic       armed
);

    unl_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= UNL_IDLE;
        end else if (key_we) begin
            case (st_q)
                UNL_IDLE: st_q <= (wdata == KEY_FIRST)  ? UNL_HALF  : UNL_IDLE;
                UNL_HALF: st_q <= (wdata == KEY_SECOND) ? UNL_ARMED : UNL_IDLE;
                default:  st_q <= UNL_IDLE;
            endcase
        end else if (ctl_we) begin
            // a control write consumes the key whether or not it starts a write
            st_q <= UNL_IDLE;
        end
    end

    assign armed = (st_q == UNL_ARMED);

endmodule

// File: rtl/nvmg_timer.sv
module nvmg_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expire,
    output logic done
);

    localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign expire = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                cnt_q <= LOAD_VAL;
            end else if (expire) begin
                done_q <= 1'b1;
            end else if (run) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/nvmg_ctlreg.sv
module nvmg_ctlreg
    import nvmg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_cold,
    input  logic       rst_warm,
    input  logic       ctl_we,
    input  logic [7:0] wdata,
    input  logic       armed,
    input  logic       expire,
    output ctl_t       q,
    output logic       accept
);

    ctl_t d;
    logic idle_write;

    assign d          = ctl_from_byte(wdata);
    assign idle_write = ctl_we && !q.wstart;
    assign accept     = idle_write && d.wstart && armed && q.wen;

    always_ff @(posedge clk) begin
        if (rst_cold) begin
            q <= '0;
        end else if (rst_warm) begin
            q.wen    <= 1'b0;
            q.wstart <= 1'b0;
            q.rstart <= 1'b0;
            q.err    <= q.err | q.wstart;
        end else begin
            q.rstart <= 1'b0;
            if (expire) begin
                q.wstart <= 1'b0;
            end
            if (idle_write) begin
                q.msel   <= d.msel;
                q.csel   <= d.csel;
                q.erase  <= d.erase;
                q.wen    <= d.wen;
                q.rstart <= d.rstart;
                if (!d.err) begin
                    q.err <= 1'b0;
                end
                if (accept) begin
                    q.wstart <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
    import nvmg_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_cold,
    input  logic       rst_warm,
    input  logic [7:0] bus_wdata,
    input  logic       ctl_we,
    input  logic       key_we,
    output logic [7:0] ctl_rdata,
    output logic [7:0] key_rdata,
    output logic       cpu_stall,
    output logic       wr_done,
    output logic       rd_strobe
);

    logic any_rst;
    logic unl_armed;
    logic start_ok;
    logic tmr_expire;
    ctl_t ctl_q;

    assign any_rst = rst_cold | rst_warm;

    nvmg_unlock u_unlock (
        .clk    (clk),
        .rst    (any_rst),
        .key_we (key_we),
        .ctl_we (ctl_we),
        .wdata  (bus_wdata),
        .armed  (unl_armed)
    );

    nvmg_ctlreg u_ctl (
        .clk      (clk),
        .rst_cold (rst_cold),
        .rst_warm (rst_warm),
        .ctl_we   (ctl_we),
        .wdata    (bus_wdata),
        .armed    (unl_armed),
        .expire   (tmr_expire),
        .q        (ctl_q),
        .accept   (start_ok)
    );

    nvmg_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (any_rst),
        .load   (start_ok),
        .run    (ctl_q.wstart),
        .expire (tmr_expire),
        .done   (wr_done)
    );

    assign ctl_rdata = ctl_view(ctl_q);
    assign key_rdata = 8'h00;
    assign cpu_stall = ctl_q.wstart & ctl_q.msel;
    assign rd_strobe = ctl_q.rstart;

endmodule

// File: rtl/nvmg_checker.sv
module nvmg_checker (
    input logic       clk,
    input logic       rst_cold,
    input logic       rst_warm,
    input logic       ctl_we,
    input logic       armed,
    input logic [7:0] ctl_rdata,
    input logic       cpu_stall,
    input logic       wr_done
);

    // R3 R4: a start needs the key, a control write and enable already held
    assert_start_keyed_R3: assert property (@(posedge clk) disable iff (rst_cold)
        $rose(ctl_rdata[1]) |-> $past(armed && ctl_we && ctl_rdata[2] && !rst_warm));

    // R5: completion pulse follows the start bit falling
    assert_done_edge_R5: assert property (@(posedge clk) disable iff (rst_cold)
        wr_done |-> ($past(ctl_rdata[1]) && !ctl_rdata[1]));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst_cold)
        wr_done |=> !wr_done);

    // R6: stall can only begin after a bus write to the control register
    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst_cold)
        $rose(cpu_stall) |-> $past(ctl_we));

    // R8 R9: the error flag only rises from a warm reset during a write
    assert_err_source_R8: assert property (@(posedge clk) disable iff (rst_cold)
        $rose(ctl_rdata[3]) |-> $past(rst_warm && ctl_rdata[1]));

    assert_warm_clears_R9: assert property (@(posedge clk) disable iff (rst_cold)
        rst_warm |=> (ctl_rdata[2:0] == 3'b000));

endmodule

bind nvm_write_guard nvmg_checker u_nvmg_chk (
    .clk       (clk),
    .rst_cold  (rst_cold),
    .rst_warm  (rst_warm),
    .ctl_we    (ctl_we),
    .armed     (unl_armed),
    .ctl_rdata (ctl_rdata),
    .cpu_stall (cpu_stall),
    .wr_done   (wr_done)
);

// File: tb/test_nvm_write_guard.sv
module test_nvm_write_guard;

    localparam int BUSY = 8;
    localparam logic [1:0] OP_CTL = 2'd0, OP_KEY = 2'd1, OP_NONE = 2'd2;

    // {requirement number, op, data, expected ctl_rdata}
    localparam int NV = 29;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  OP_CTL,  8'h04, 8'h04},  // R1 write enable
        {4'd3,  OP_CTL,  8'h06, 8'h04},  // R3 no key at all
        {4'd3,  OP_KEY,  8'h55, 8'h04},
        {4'd3,  OP_KEY,  8'h00, 8'h04},  // wrong byte
        {4'd3,  OP_KEY,  8'hAA, 8'h04},
        {4'd3,  OP_CTL,  8'h06, 8'h04},  // R3 broken key
        {4'd3,  OP_KEY,  8'h55, 8'h04},
        {4'd3,  OP_KEY,  8'h55, 8'h04},  // repeated first byte
        {4'd3,  OP_KEY,  8'hAA, 8'h04},
        {4'd3,  OP_CTL,  8'h06, 8'h04},  // R3 repeated 0x55
        {4'd3,  OP_KEY,  8'h55, 8'h04},
        {4'd3,  OP_KEY,  8'hAA, 8'h04},
        {4'd3,  OP_CTL,  8'h04, 8'h04},  // intervening control write
        {4'd3,  OP_CTL,  8'h06, 8'h04},  // R3 key consumed
        {4'd1,  OP_CTL,  8'h00, 8'h00},
        {4'd4,  OP_KEY,  8'h55, 8'h00},
        {4'd4,  OP_KEY,  8'hAA, 8'h00},
        {4'd4,  OP_CTL,  8'h02, 8'h00},  // R4 enable clear
        {4'd1,  OP_CTL,  8'h10, 8'h10},  // R1 erase enable
        {4'd1,  OP_CTL,  8'hC4, 8'hC4},  // R1 selects
        {4'd8,  OP_CTL,  8'hFF, 8'hD5},  // R8 err not settable, R1 bit5 zero
        {4'd11, OP_NONE, 8'h00, 8'hD4},  // R11 read start self-clears
        {4'd1,  OP_CTL,  8'h00, 8'h00},
        {4'd4,  OP_KEY,  8'h55, 8'h00},
        {4'd4,  OP_KEY,  8'hAA, 8'h00},
        {4'd4,  OP_CTL,  8'h06, 8'h04},  // R4 enable written together: refused
        {4'd1,  OP_CTL,  8'h00, 8'h00},
        {4'd1,  OP_NONE, 8'h00, 8'h00},
        {4'd1,  OP_NONE, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_cold = 1'b1;
    logic       rst_warm = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       ctl_we = 1'b0;
    logic       key_we = 1'b0;
    logic [7:0] ctl_rdata, key_rdata;
    logic       cpu_stall, wr_done, rd_strobe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvm_write_guard #(.BUSY_CYCLES(BUSY)) i_nvm_write_guard (
        .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
        .bus_wdata(bus_wdata), .ctl_we(ctl_we), .key_we(key_we),
        .ctl_rdata(ctl_rdata), .key_rdata(key_rdata),
        .cpu_stall(cpu_stall), .wr_done(wr_done), .rd_strobe(rd_strobe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive after a falling edge, sample at the next one
    task automatic step(logic [1:0] op, logic [7:0] data);
        bus_wdata = data;
        ctl_we    = (op == OP_CTL);
        key_we    = (op == OP_KEY);
        @(negedge clk);
        ctl_we = 1'b0;
        key_we = 1'b0;
    endtask

    task automatic pulse_warm();
        rst_warm = 1'b1;
        @(negedge clk);
        rst_warm = 1'b0;
    endtask

    task automatic start_write(logic [7:0] setup);
        step(OP_CTL, setup);
        step(OP_KEY, 8'h55);
        step(OP_KEY, 8'hAA);
        step(OP_CTL, setup | 8'h02);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_cold = 1'b0;
        // R10 reset state
        chk("R10 reset ctl", ctl_rdata, 8'h00);
        chk("R10 reset stall/done", {6'b0, cpu_stall, wr_done}, 8'h00);
        chk("R2 key read", key_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:16], VEC[i][15:8]);
            n_chk++;
            if (ctl_rdata !== VEC[i][7:0]) begin
                n_fail++;
                $display("FAIL R%0d row %0d: actual %h expected %h",
                         VEC[i][21:18], i, ctl_rdata, VEC[i][7:0]);
            end
        end

        // R11 strobe
        step(OP_CTL, 8'h01);
        chk("R11 rd_strobe high", {7'b0, rd_strobe}, 8'h01);
        step(OP_NONE, 8'h00);
        chk("R11 rd_strobe low", {7'b0, rd_strobe}, 8'h00);

        // R2 key location stores nothing
        step(OP_KEY, 8'hAA);
        chk("R2 key read after write", key_rdata, 8'h00);
        step(OP_NONE, 8'h00);

        // R5 R6 R7 program-memory write
        start_write(8'h84);
        chk("R5 accepted", ctl_rdata, 8'h86);
        chk("R6 stall high", {7'b0, cpu_stall}, 8'h01);
        for (int k = 1; k <= BUSY + 1; k++) begin
            step((k == 3) ? OP_CTL : OP_NONE, 8'h00);
            if (k < BUSY) begin
                chk("R7 R5 still busy", ctl_rdata, 8'h86);
                chk("R5 no early done", {7'b0, wr_done}, 8'h00);
            end else if (k == BUSY) begin
                chk("R5 start cleared", ctl_rdata, 8'h84);
                chk("R5 done pulse", {7'b0, wr_done}, 8'h01);
                chk("R6 stall released", {7'b0, cpu_stall}, 8'h00);
            end else begin
                chk("R5 done one cycle", {7'b0, wr_done}, 8'h00);
            end
        end

        // R6 data-memory write does not stall
        start_write(8'h04);
        chk("R6 data write busy", ctl_rdata, 8'h06);
        chk("R6 no stall", {7'b0, cpu_stall}, 8'h00);
        repeat (BUSY) step(OP_NONE, 8'h00);
        chk("R5 data write done", {7'b0, wr_done}, 8'h01);

        // R9 warm reset during a write
        start_write(8'h94);
        step(OP_NONE, 8'h00);
        pulse_warm();
        chk("R9 warm abort", ctl_rdata, 8'h98);
        chk("R9 stall dropped", {7'b0, cpu_stall}, 8'h00);
        for (int k = 0; k < BUSY + 2; k++) begin
            step(OP_NONE, 8'h00);
            chk("R9 no done after abort", {7'b0, wr_done}, 8'h00);
        end
        pulse_warm();
        chk("R9 warm keeps err", ctl_rdata, 8'h98);

        // R8 clear by writing 0, writing 1 keeps
        step(OP_CTL, 8'h88);
        chk("R8 write 1 keeps", ctl_rdata, 8'h88);
        step(OP_CTL, 8'h80);
        chk("R8 write 0 clears", ctl_rdata, 8'h80);

        // R10 cold reset clears all, including err, and beats warm
        step(OP_NONE, 8'h00);
        start_write(8'h84);
        rst_cold = 1'b1;
        rst_warm = 1'b1;
        @(negedge clk);
        rst_cold = 1'b0;
        rst_warm = 1'b0;
        chk("R10 cold clears", ctl_rdata, 8'h00);
        chk("R10 cold drops stall", {7'b0, cpu_stall}, 8'h00);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule